// File: doc/BRIEF.md
# Serial-Operand Pipelined ALU

This block is a small clocked arithmetic unit fed through one shared data input. A command and the first operand arrive together. The second operand follows on the same data lines one cycle later. A fixed pipeline then produces the result, and the result is presented together with a one-cycle valid strobe. Three operations are supported: addition, subtraction and bitwise AND. All three use the same two-beat capture and the same latency.

A `busy` output covers the whole operation. While `busy` is high, any command on the input is disregarded. The result and its carry/borrow bit stay on the outputs until the next result replaces them. Reset is asynchronous and active-low. Asserting it abandons any operation in progress and clears the outputs.

Top module: `alu2b_top`

## Requirements
- R1: In idle, a command other than no-operation is accepted on a rising edge, and the value on `data_i` at that same edge is taken as the first operand A. Command encoding: 00 no-operation, 01 add, 10 subtract (A minus B), 11 bitwise AND.
- R2: The value on `data_i` at the rising edge that follows the accepting edge is taken as the second operand B.
- R3: `result_o` holds the operation result, truncated to `DATA_W` bits with wraparound. It is correct, with `valid_o` high, in the cycle after the third rising edge that follows the B-capture edge.
- R4: `carry_o` is registered with the result. For add it is the carry out of the full sum. For subtract it is the borrow, which is 1 when A < B. For AND it is 0.
- R5: `valid_o` is high for exactly one cycle per operation.
- R6: `busy_o` is high from the cycle after the accepting edge through the cycle in which `valid_o` is high, and is low otherwise.
- R7: A command present on any rising edge while `busy_o` is high is ignored. It does not change the operands, the operation in progress or its result.
- R8: A command presented in the first cycle with `busy_o` low is accepted on that cycle's closing edge.
- R9: `result_o` and `carry_o` hold their last values in every cycle in which `valid_o` is low.
- R10: While `rst_n` is low, `result_o`, `carry_o`, `valid_o` and `busy_o` are 0. Any operation in progress is abandoned, and after release the block is idle.
- R11: A no-operation command in idle starts nothing: `busy_o` and `valid_o` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2 | Operation command (00 nop, 01 add, 10 sub, 11 and) |
| data_i | input | DATA_W | Shared operand input, A then B on consecutive edges |
| result_o | output | DATA_W | Registered result, held until the next result |
| carry_o | output | 1 | Carry (add) or borrow (sub) registered with the result |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| busy_o | output | 1 | High while an operation is in progress |

## Verification
The embedded assertions check the following on every cycle: operand capture on the accepting edge and the edge after it, the fixed distance from B capture to the valid strobe, the single-cycle width of that strobe, the output holding between strobes, and the refusal of new starts while busy. The arithmetic itself, meaning the truncated sums, differences, AND results and the carry/borrow bit, is shown only by the bench's exhaustive sweep over a 4-bit configuration. The same applies to the exact edge on which a follow-on command is accepted and to recovery from a reset in mid-operation.

// File: rtl/alu2b_pkg.sv
package alu2b_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_ADD = 2'b01,
    CMD_SUB = 2'b10,
    CMD_AND = 2'b11
  } cmd_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_OPB  = 3'd1,
    PH_EX1  = 3'd2,
    PH_EX2  = 3'd3,
    PH_EX3  = 3'd4,
    PH_DONE = 3'd5
  } phase_e;

  // edges from operand-B capture to the result register load
  localparam int unsigned RESULT_LAT = 3;

endpackage

// File: rtl/alu2b_seq.sv
module alu2b_seq
  import alu2b_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  cmd_e   cmd_i,
  output phase_e phase_o,
  output logic   accept_o,
  output logic   busy_o
);

  phase_e phase_q, phase_d;

  assign accept_o = (phase_q == PH_IDLE) && (cmd_i != CMD_NOP);
  assign busy_o   = (phase_q != PH_IDLE);
  assign phase_o  = phase_q;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (accept_o) phase_d = PH_OPB;
      PH_OPB:  phase_d = PH_EX1;
      PH_EX1:  phase_d = PH_EX2;
      PH_EX2:  phase_d = PH_EX3;
      PH_EX3:  phase_d = PH_DONE;
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  AST_ACCEPT_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && cmd_i != CMD_NOP) |=> (phase_q == PH_OPB)); // R1
  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> (phase_q != PH_OPB)); // R7
  AST_NOP_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && cmd_i == CMD_NOP) |=> (phase_q == PH_IDLE)); // R11

endmodule

// File: rtl/alu2b_capture.sv
module alu2b_capture
  import alu2b_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  phase_e            phase_i,
  input  cmd_e              cmd_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] op_a_o,
  output logic [DATA_W-1:0] op_b_o,
  output cmd_e              cmd_o
);

  logic [DATA_W-1:0] op_a_q, op_a_d;
  logic [DATA_W-1:0] op_b_q, op_b_d;
  cmd_e              cmd_q,  cmd_d;
  logic              load_b;

  assign load_b = (phase_i == PH_OPB);

  always_comb begin
    op_a_d = accept_i ? data_i : op_a_q;
    cmd_d  = accept_i ? cmd_i  : cmd_q;
    op_b_d = load_b   ? data_i : op_b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_a_q <= '0;
      op_b_q <= '0;
      cmd_q  <= CMD_NOP;
    end else begin
      op_a_q <= op_a_d;
      op_b_q <= op_b_d;
      cmd_q  <= cmd_d;
    end
  end

  assign op_a_o = op_a_q;
  assign op_b_o = op_b_q;
  assign cmd_o  = cmd_q;

  AST_OPA_ON_CMD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> (op_a_q == $past(data_i))); // R1
  AST_OPB_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_OPB) |=> (op_b_q == $past(data_i))); // R2
  AST_OPA_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i != PH_IDLE) |=> $stable(op_a_q)); // R7

endmodule

// File: rtl/alu2b_exec.sv
module alu2b_exec
  import alu2b_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_i,
  input  cmd_e              cmd_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              valid_o
);

  localparam int unsigned EXT_W = DATA_W + 1;

  logic [EXT_W-1:0] raw;
  logic [EXT_W-1:0] s1_q, s1_d;
  logic [EXT_W-1:0] s2_q, s2_d;
  logic [EXT_W-1:0] out_q, out_d;
  logic             valid_q, valid_d;
  logic             en_s1, en_s2, en_out;

  assign en_s1  = (phase_i == PH_EX1);
  assign en_s2  = (phase_i == PH_EX2);
  assign en_out = (phase_i == PH_EX3);

  always_comb begin
    unique case (cmd_i)
      CMD_ADD: raw = {1'b0, op_a_i} + {1'b0, op_b_i};
      CMD_SUB: raw = {1'b0, op_a_i} - {1'b0, op_b_i};
      CMD_AND: raw = {1'b0, op_a_i & op_b_i};
      default: raw = '0;
    endcase
  end

  always_comb begin
    s1_d    = en_s1  ? raw  : s1_q;
    s2_d    = en_s2  ? s1_q : s2_q;
    out_d   = en_out ? s2_q : out_q;
    valid_d = en_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= '0;
      s2_q    <= '0;
      out_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      s1_q    <= s1_d;
      s2_q    <= s2_d;
      out_q   <= out_d;
      valid_q <= valid_d;
    end
  end

  assign result_o = out_q[DATA_W-1:0];
  assign carry_o  = out_q[DATA_W];
  assign valid_o  = valid_q;

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R5
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(out_q)); // R9

endmodule

// File: rtl/alu2b_top.sv
module alu2b_top
  import alu2b_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              valid_o,
  output logic              busy_o
);

  cmd_e              cmd_in;
  cmd_e              cmd_held;
  phase_e            phase;
  logic              accept;
  logic [DATA_W-1:0] op_a, op_b;

  assign cmd_in = cmd_e'(cmd_i);

  alu2b_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_i    (cmd_in),
    .phase_o  (phase),
    .accept_o (accept),
    .busy_o   (busy_o)
  );

  alu2b_capture #(.DATA_W(DATA_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .phase_i  (phase),
    .cmd_i    (cmd_in),
    .data_i   (data_i),
    .op_a_o   (op_a),
    .op_b_o   (op_b),
    .cmd_o    (cmd_held)
  );

  alu2b_exec #(.DATA_W(DATA_W)) u_exec (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_i  (phase),
    .cmd_i    (cmd_held),
    .op_a_i   (op_a),
    .op_b_i   (op_b),
    .result_o (result_o),
    .carry_o  (carry_o),
    .valid_o  (valid_o)
  );

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OPB) |-> ##4 valid_o); // R3
  AST_BUSY_COVERS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> busy_o); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |-> (!valid_o && !busy_o && result_o == '0 && !carry_o)); // R10

endmodule

// File: tb/tb_alu2b_top.sv
`timescale 1ns/1ps
module tb_alu2b_top;

  localparam int W = 4;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   cmd_i;
  logic [W-1:0] data_i;
  logic [W-1:0] result_o;
  logic         carry_o, valid_o, busy_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  alu2b_top #(.DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .data_i(data_i),
    .result_o(result_o), .carry_o(carry_o), .valid_o(valid_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_res(input int c, input int a, input int b);
    case (c)
      1: return (a + b) & MASK;
      2: return (a - b) & MASK;
      default: return a & b;
    endcase
  endfunction

  function automatic int exp_cy(input int c, input int a, input int b);
    case (c)
      1: return ((a + b) >> W) & 1;
      2: return (a < b) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  // Called at a negedge with the block idle; returns at the negedge
  // after the valid cycle, block idle again.
  task automatic run_op(input int c, input int a, input int b, input int junk);
    int prev;
    prev = result_o;
    cmd_i = c[1:0]; data_i = a[W-1:0];
    tick();                                   // accepting edge: A taken
    chk(busy_o == 1'b1, "R6 busy after accept", busy_o, 1);
    cmd_i = junk[1:0]; data_i = b[W-1:0];     // busy command must be ignored
    tick();                                   // B taken
    data_i = W'(~b);
    cmd_i = junk[1:0] ^ 2'b01;
    for (int k = 0; k < 2; k++) begin
      tick();
      chk(valid_o == 1'b0, "R3 no early valid", valid_o, 0);
      chk(result_o == prev[W-1:0], "R9 result held", result_o, prev);
    end
    tick();                                   // third edge after B
    chk(valid_o == 1'b1, "R3 valid timing", valid_o, 1);
    chk(result_o == exp_res(c, a, b), "R3 result value", result_o, exp_res(c, a, b));
    chk(carry_o == exp_cy(c, a, b), "R4 carry/borrow", carry_o, exp_cy(c, a, b));
    chk(busy_o == 1'b1, "R6 busy in valid cycle", busy_o, 1);
    tick();                                   // command here ignored (R7)
    chk(valid_o == 1'b0, "R5 single-cycle valid", valid_o, 0);
    chk(busy_o == 1'b0, "R6 busy released", busy_o, 0);
    chk(result_o == exp_res(c, a, b), "R9 result held after valid", result_o, exp_res(c, a, b));
    chk(carry_o == exp_cy(c, a, b), "R9 carry held", carry_o, exp_cy(c, a, b));
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; cmd_i = 2'b00; data_i = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(result_o == 0 && carry_o == 0, "R10 reset outputs", result_o, 0);
    chk(valid_o == 0 && busy_o == 0, "R10 reset flags", valid_o | busy_o, 0);
    rst_n = 1'b1;
    tick();

    // R11: no-operation in idle starts nothing
    for (int k = 0; k < 6; k++) begin
      cmd_i = 2'b00; data_i = W'(k * 3);
      tick();
      chk(busy_o == 0 && valid_o == 0, "R11 nop idle", busy_o | valid_o, 0);
    end

    // R1-style exhaustive sweep: every command, every operand pair
    for (int c = 1; c < 4; c++)
      for (int a = 0; a <= MASK; a++)
        for (int b = 0; b <= MASK; b++)
          run_op(c, a, b, (a + b + c) % 4);

    // R8: command in first non-busy cycle accepted at that cycle's edge
    run_op(1, 9, 9, 3);
    cmd_i = 2'b10; data_i = 4'd5;
    tick();
    chk(busy_o == 1'b1, "R8 immediate accept", busy_o, 1);
    data_i = 4'd7; cmd_i = 2'b00;
    repeat (4) tick();
    chk(valid_o == 1 && result_o == 4'd14 && carry_o == 1, "R8 follow-on result", result_o, 14);
    tick();

    // R2: B is the value at the edge after acceptance, not later
    cmd_i = 2'b01; data_i = 4'd1;
    tick();
    cmd_i = 2'b00; data_i = 4'd2;
    tick();
    data_i = 4'd12;
    repeat (3) tick();
    chk(valid_o == 1 && result_o == 4'd3, "R2 second operand edge", result_o, 3);
    tick();

    // R10: reset in mid-operation aborts
    cmd_i = 2'b01; data_i = 4'd6;
    tick();
    data_i = 4'd6; cmd_i = 2'b00;
    tick();
    #1 rst_n = 1'b0;
    #0.5;
    chk(busy_o == 0 && valid_o == 0 && result_o == 0, "R10 abort clears", busy_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      tick();
      chk(valid_o == 0 && busy_o == 0, "R10 abandoned op gives no result", valid_o, 0);
    end
    run_op(3, 13, 7, 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule